// File: doc/BRIEF.md
# ADC Conversion Control and Status Sequencer

This block supervises an external successive-approximation converter core through one 16-bit memory-mapped control/status word. Software, or an external trigger line picked by a two-bit source field, starts a scan. The block then hands the core one channel number at a time with a one-cycle start strobe and waits for the core's done strobe. The scan runs from a start channel up to an end channel, modulo 8.

Each accepted done strobe sets a data-ready flag. That flag raises an interrupt request when it is enabled, and it also raises a DMA request when DMA is selected. Three scan modes decide what happens after the last channel:
- Single mode stops the scan.
- Continuous mode goes round again.
- Pause mode halts after every channel until the next trigger.

The running flag reads differently on a read-modify-write access. Clearing it by a write aborts the scan.

Top module: `adc_ctl_seq`

## Requirements
- R1: Word layout on `bus_rdata`: bit 15 running flag, bit 14 data-ready flag, bit 13 interrupt enable, bit 12 paused flag, bits 11:10 start source, bit 9 start strobe (always reads 0), bit 8 reserved (reads 0), bits 7:6 mode, bits 5:3 start channel, bits 2:0 end channel. Every field is 0 after reset.
- R2: When idle, a write with bit 9 set, or a rising edge on `ext_trig[k-1]` while the source field equals k (k = 1..3), sets the running flag and pulses `conv_start` with `conv_chan` equal to the start channel. With source 00, or on a trigger line that is not selected, no start occurs.
- R3: Channels are converted in ascending order from the start channel to the end channel, modulo 8. If the two are equal, exactly one channel is converted.
- R4: Mode encoding: 00 single, 01 continuous, 10 pause, 11 single. In single mode, the running flag clears when the end channel's conversion is done.
- R5: In continuous mode, the scan returns to the start channel after the end channel, and the running flag stays set.
- R6: In pause mode, each done sets the paused flag and no new start is issued until a trigger arrives. The trigger clears the paused flag and converts the next channel in scan order.
- R7: A write with bit 15 at 0 while running pulses `conv_abort` and clears the running and paused flags, and no further `conv_start` follows. This holds even when bit 9 is set in the same write. Writing 1 to bit 15 has no effect.
- R8: While `bus_rmw` is high, bit 15 of `bus_rdata` reads 1.
- R9: Each `conv_done` accepted during a conversion sets the data-ready flag.
- R10: Writing 1 to the data-ready flag has no effect. Writing 0 to it, or pulsing `dma_clr`, clears it, and a simultaneous done wins.
- R11: `irq` is high exactly when the data-ready flag and the interrupt enable are both set. `dma_req` is additionally gated by `dma_sel`.
- R12: While running, writes leave the source, mode, start channel and end channel fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rmw | input | 1 | Current read belongs to a read-modify-write access |
| bus_rdata | output | 16 | Register read value |
| ext_trig | input | 3 | External start trigger lines |
| dma_sel | input | 1 | Enables the DMA request path |
| dma_clr | input | 1 | DMA acknowledge, clears data-ready flag |
| conv_start | output | 1 | One-cycle start strobe to converter core |
| conv_abort | output | 1 | One-cycle abort strobe to converter core |
| conv_chan | output | 3 | Channel for the current conversion |
| conv_done | input | 1 | Converter core finished a conversion |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The scan is exercised with several channel windows:
- An ascending window tells in-order stepping apart from skipping.
- A window with the start channel above the end channel exposes the modulo-8 wrap.
- An equal pair checks that exactly one conversion occurs.

The three modes are each run against the same queue of expected channels. This separates stopping, wrapping with the running flag held, and halting between channels. An abort that carries the start bit as well shows that the abort wins. Pulses on a selected and an unselected trigger line show that the source select really picks one line.

// File: rtl/adc_ctl_pkg.sv
package adc_ctl_pkg;
  localparam int REG_W   = 16;
  localparam int CH_W    = 3;
  localparam int STS_W   = 2;
  localparam int MD_W    = 2;
  localparam int N_TRIG  = (1 << STS_W) - 1;

  localparam int RUN_B   = 15;
  localparam int RDY_B   = 14;
  localparam int IEN_B   = 13;
  localparam int PSE_B   = 12;
  localparam int SRC_LSB = 10;
  localparam int GO_B    = 9;
  localparam int MD_LSB  = 6;
  localparam int FST_LSB = 3;
  localparam int LST_LSB = 0;

  typedef enum logic [MD_W-1:0] {
    MD_SINGLE = 2'b00,
    MD_CONT   = 2'b01,
    MD_PAUSE  = 2'b10,
    MD_SGL_B  = 2'b11
  } scan_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_CONV  = 2'b01,
    ST_HOLD  = 2'b10
  } seq_state_e;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
  import adc_ctl_pkg::*;
#(
  parameter int SRC_W = STS_W,
  localparam int NT   = (1 << SRC_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NT-1:0]    ext_trig,
  input  logic [SRC_W-1:0] src_sel,
  input  logic             sw_go,
  output logic             trig
);
  logic [NT-1:0] ext_q;
  logic [NT-1:0] rise;
  logic          sel_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_q <= '0;
    else        ext_q <= ext_trig;
  end

  assign rise = ext_trig & ~ext_q;

  always_comb begin
    sel_rise = 1'b0;
    for (int k = 1; k <= NT; k++) begin
      if (src_sel == SRC_W'(k)) sel_rise = rise[k-1];
    end
  end

  assign trig = sw_go | sel_rise;

  // R2
  no_src_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == '0 && !sw_go) |-> !trig);
endmodule

// File: rtl/adc_chan_step.sv
module adc_chan_step #(
  parameter int W = adc_ctl_pkg::CH_W
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] first,
  input  logic [W-1:0] last_ch,
  output logic         at_end,
  output logic [W-1:0] nxt
);
  assign at_end = (cur == last_ch);
  assign nxt    = at_end ? first : W'(cur + 1'b1);
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_ctl_pkg::*;
#(
  parameter int W = CH_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig,
  input  logic       abort_req,
  input  logic       conv_done,
  input  scan_mode_e mode,
  input  logic [W-1:0] first_eff,
  input  logic [W-1:0] first,
  input  logic [W-1:0] last_ch,
  output logic       running,
  output logic       paused,
  output logic [W-1:0] chan,
  output logic       start_p,
  output logic       abort_p,
  output logic       done_acc
);
  seq_state_e st_q, st_d;
  logic         run_d, pse_d, start_d, abort_d;
  logic [W-1:0] ch_d;
  logic         at_end;
  logic [W-1:0] ch_nxt;

  adc_chan_step #(.W(W)) step_i (
    .cur(chan), .first(first), .last_ch(last_ch),
    .at_end(at_end), .nxt(ch_nxt)
  );

  always_comb begin
    st_d     = st_q;
    run_d    = running;
    pse_d    = paused;
    ch_d     = chan;
    start_d  = 1'b0;
    abort_d  = 1'b0;
    done_acc = 1'b0;
    if (abort_req) begin
      st_d    = ST_IDLE;
      run_d   = 1'b0;
      pse_d   = 1'b0;
      abort_d = 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (trig) begin
          st_d    = ST_CONV;
          run_d   = 1'b1;
          ch_d    = first_eff;
          start_d = 1'b1;
        end
        ST_CONV: if (conv_done) begin
          done_acc = 1'b1;
          unique case (mode)
            MD_PAUSE: begin
              st_d  = ST_HOLD;
              pse_d = 1'b1;
              ch_d  = ch_nxt;
            end
            MD_CONT: begin
              ch_d    = ch_nxt;
              start_d = 1'b1;
            end
            default: begin
              if (at_end) begin
                st_d  = ST_IDLE;
                run_d = 1'b0;
              end else begin
                ch_d    = ch_nxt;
                start_d = 1'b1;
              end
            end
          endcase
        end
        ST_HOLD: if (trig) begin
          st_d    = ST_CONV;
          pse_d   = 1'b0;
          start_d = 1'b1;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      running <= 1'b0;
      paused  <= 1'b0;
      chan    <= '0;
      start_p <= 1'b0;
      abort_p <= 1'b0;
    end else begin
      st_q    <= st_d;
      running <= run_d;
      paused  <= pse_d;
      chan    <= ch_d;
      start_p <= start_d;
      abort_p <= abort_d;
    end
  end

  // R7
  abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> (abort_p && !running && !paused && !start_p));
  // R2
  start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |-> running);
  // R5
  cont_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && mode == MD_CONT && !abort_req) |=> running);
  // R6
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (paused && !trig) |=> !start_p);
endmodule

// File: rtl/adc_flag_reg.sv
module adc_flag_reg
  import adc_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             running,
  input  logic             done_acc,
  input  logic             dma_clr,
  output logic             rdy_q,
  output logic             ien_q,
  output logic [STS_W-1:0] src_q,
  output scan_mode_e       mode_q,
  output logic [CH_W-1:0]  first_q,
  output logic [CH_W-1:0]  last_q
);
  logic             rdy_d, ien_d, cfg_en;
  logic [STS_W-1:0] src_d;
  scan_mode_e       mode_d;
  logic [CH_W-1:0]  first_d, last_d;

  assign cfg_en = wr && !running;

  always_comb begin
    rdy_d = rdy_q;
    if (done_acc)                        rdy_d = 1'b1;
    else if (dma_clr || (wr && !wdata[RDY_B])) rdy_d = 1'b0;
    ien_d   = wr ? wdata[IEN_B] : ien_q;
    src_d   = cfg_en ? wdata[SRC_LSB +: STS_W] : src_q;
    mode_d  = cfg_en ? scan_mode_e'(wdata[MD_LSB +: MD_W]) : mode_q;
    first_d = cfg_en ? wdata[FST_LSB +: CH_W] : first_q;
    last_d  = cfg_en ? wdata[LST_LSB +: CH_W] : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q   <= 1'b0;
      ien_q   <= 1'b0;
      src_q   <= '0;
      mode_q  <= MD_SINGLE;
      first_q <= '0;
      last_q  <= '0;
    end else begin
      rdy_q   <= rdy_d;
      ien_q   <= ien_d;
      src_q   <= src_d;
      mode_q  <= mode_d;
      first_q <= first_d;
      last_q  <= last_d;
    end
  end

  // R9
  done_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_acc |=> rdy_q);
  // R10
  rdy_wr1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[RDY_B] && !rdy_q && !done_acc) |=> !rdy_q);
  // R12
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ($stable(mode_q) && $stable(first_q) && $stable(last_q) && $stable(src_q)));
endmodule

// File: rtl/adc_ctl_seq.sv
module adc_ctl_seq
  import adc_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic              bus_rmw,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [N_TRIG-1:0] ext_trig,
  input  logic              dma_sel,
  input  logic              dma_clr,
  output logic              conv_start,
  output logic              conv_abort,
  output logic [CH_W-1:0]   conv_chan,
  input  logic              conv_done,
  output logic              irq,
  output logic              dma_req
);
  logic             running, paused, done_acc, trig, abort_req, sw_go;
  logic             rdy_q, ien_q;
  logic [STS_W-1:0] src_q;
  scan_mode_e       mode_q;
  logic [CH_W-1:0]  first_q, last_q, first_eff;

  assign abort_req = bus_wr && !bus_wdata[RUN_B] && running;
  assign sw_go     = bus_wr && bus_wdata[GO_B];
  assign first_eff = (bus_wr && !running) ? bus_wdata[FST_LSB +: CH_W] : first_q;

  adc_trig_sel #(.SRC_W(STS_W)) trig_i (
    .clk(clk), .rst_n(rst_n), .ext_trig(ext_trig), .src_sel(src_q),
    .sw_go(sw_go), .trig(trig)
  );

  adc_flag_reg flag_i (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .wdata(bus_wdata),
    .running(running), .done_acc(done_acc), .dma_clr(dma_clr),
    .rdy_q(rdy_q), .ien_q(ien_q), .src_q(src_q), .mode_q(mode_q),
    .first_q(first_q), .last_q(last_q)
  );

  adc_seq_fsm #(.W(CH_W)) fsm_i (
    .clk(clk), .rst_n(rst_n), .trig(trig), .abort_req(abort_req),
    .conv_done(conv_done), .mode(mode_q), .first_eff(first_eff),
    .first(first_q), .last_ch(last_q), .running(running), .paused(paused),
    .chan(conv_chan), .start_p(conv_start), .abort_p(conv_abort),
    .done_acc(done_acc)
  );

  always_comb begin
    bus_rdata = '0;
    bus_rdata[RUN_B]               = running | bus_rmw;
    bus_rdata[RDY_B]               = rdy_q;
    bus_rdata[IEN_B]               = ien_q;
    bus_rdata[PSE_B]               = paused;
    bus_rdata[SRC_LSB +: STS_W]    = src_q;
    bus_rdata[MD_LSB +: MD_W]      = mode_q;
    bus_rdata[FST_LSB +: CH_W]     = first_q;
    bus_rdata[LST_LSB +: CH_W]     = last_q;
  end

  assign irq     = rdy_q & ien_q;
  assign dma_req = irq & dma_sel;

  // R8
  rmw_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rmw |-> bus_rdata[RUN_B]);
  // R11
  dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (irq && dma_sel));
endmodule

// File: tb/adc_ctl_seq_tb.sv
module adc_ctl_seq_tb_top;
  localparam int CLK_PER = 10;

  logic        clk, rst_n, bus_wr, bus_rmw, dma_sel, dma_clr, conv_done;
  logic [15:0] bus_wdata, bus_rdata;
  logic [2:0]  ext_trig, conv_chan;
  logic        conv_start, conv_abort, irq, dma_req;

  int n_chk = 0, n_fail = 0, start_cnt = 0, pend = 0;
  bit auto_en = 1, finished = 0;
  int exp_q[$];

  adc_ctl_seq dut_i (.*);

  initial clk = 0;
  always #(CLK_PER/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: scoreboard of issued channels
  always @(negedge clk) begin
    if (rst_n && conv_start) begin
      start_cnt++;
      if (exp_q.size() == 0) check(0, "R7 unexpected start", conv_chan, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(conv_chan == e[2:0], "R3 channel order", conv_chan, e);
      end
    end
  end

  // converter core model
  always @(negedge clk) begin
    conv_done = 0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) conv_done = 1;
    end
    if (conv_abort) pend = 0;
    if (conv_start && auto_en) pend = 3;
  end

  function automatic logic [15:0] mk(logic b, logic r, logic ie, logic [1:0] s,
                                     logic go, logic [1:0] md, logic [2:0] a, logic [2:0] e);
    return {b, r, ie, 1'b0, s, go, 1'b0, md, a, e};
  endfunction

  task automatic reg_wr(input logic [15:0] d);
    @(negedge clk); bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic wait_bit(input int b, input logic v, input string tag);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (bus_rdata[b] == v) return;
    end
    check(0, tag, bus_rdata[b], v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 0; bus_wr = 0; bus_wdata = 0; bus_rmw = 0; ext_trig = 0;
    dma_sel = 0; dma_clr = 0; conv_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    check(bus_rdata == 16'h0, "R1 reset word", bus_rdata, 0);
    check({irq, dma_req, conv_start, conv_abort} == 0, "R1 reset outputs", {irq, dma_req}, 0);

    // configure single 2..4, write 1 to data-ready has no effect
    reg_wr(mk(0, 1, 1, 0, 1'b0, 2'b00, 3'd2, 3'd4)); #1;
    check(bus_rdata == 16'h2014, "R1 R10 readback", bus_rdata, 16'h2014);

    dma_sel = 1;
    exp_q.push_back(2); exp_q.push_back(3); exp_q.push_back(4);
    reg_wr(mk(0, 1, 1, 0, 1'b1, 2'b00, 3'd2, 3'd4)); #1;
    check(bus_rdata[15] == 1 && bus_rdata[9] == 0, "R2 running set, go reads 0", bus_rdata, 16'h8000);
    wait_bit(15, 0, "R4 single completes");
    check(exp_q.size() == 0, "R3 all channels", exp_q.size(), 0);
    check(bus_rdata[14] == 1, "R9 data-ready set", bus_rdata[14], 1);
    check(irq && dma_req, "R11 irq and dma", {irq, dma_req}, 3);
    dma_sel = 0; #1;
    check(irq && !dma_req, "R11 dma gated", {irq, dma_req}, 2);

    reg_wr(mk(0, 1, 1, 0, 1'b0, 2'b00, 3'd2, 3'd4)); #1;
    check(bus_rdata[14] == 1, "R10 write 1 keeps flag", bus_rdata[14], 1);
    reg_wr(mk(0, 0, 1, 0, 1'b0, 2'b00, 3'd2, 3'd4)); #1;
    check(bus_rdata[14] == 0 && !irq, "R10 write 0 clears", bus_rdata[14], 0);

    // wrap 6..1, interrupt disabled
    exp_q.push_back(6); exp_q.push_back(7); exp_q.push_back(0); exp_q.push_back(1);
    reg_wr(mk(0, 1, 0, 0, 1'b1, 2'b00, 3'd6, 3'd1));
    wait_bit(15, 0, "R4 wrap scan completes");
    check(exp_q.size() == 0, "R3 modulo-8 wrap", exp_q.size(), 0);
    check(bus_rdata[14] && !irq, "R11 enable off", irq, 0);
    @(negedge clk); dma_clr = 1; @(negedge clk); dma_clr = 0; #1;
    check(bus_rdata[14] == 0, "R10 dma clear", bus_rdata[14], 0);

    // single channel, mode 11
    base = start_cnt;
    exp_q.push_back(5);
    reg_wr(mk(0, 1, 0, 0, 1'b1, 2'b11, 3'd5, 3'd5));
    wait_bit(15, 0, "R4 mode 11 completes");
    check(start_cnt == base + 1, "R3 equal channels", start_cnt - base, 1);

    bus_rmw = 1; #1;
    check(bus_rdata[15] == 1, "R8 rmw reads running", bus_rdata[15], 1);
    bus_rmw = 0;

    // continuous 1..2
    base = start_cnt;
    exp_q.push_back(1); exp_q.push_back(2); exp_q.push_back(1); exp_q.push_back(2);
    reg_wr(mk(0, 1, 0, 0, 1'b1, 2'b01, 3'd1, 3'd2));
    for (int i = 0; i < 200 && start_cnt < base + 3; i++) begin @(negedge clk); #1; end
    auto_en = 0;
    for (int i = 0; i < 200 && start_cnt < base + 4; i++) begin @(negedge clk); #1; end
    idle(6);
    check(bus_rdata[15] == 1, "R5 running held", bus_rdata[15], 1);
    reg_wr(mk(1, 1, 0, 2'b11, 1'b0, 2'b00, 3'd7, 3'd7)); #1;
    check(bus_rdata[11:0] == 12'h04A, "R12 config frozen", bus_rdata[11:0], 12'h04A);
    reg_wr(mk(0, 1, 0, 0, 1'b1, 2'b01, 3'd1, 3'd2)); #1;
    check(conv_abort == 1 && bus_rdata[15] == 0, "R7 abort wins", {conv_abort, bus_rdata[15]}, 2);
    idle(10);
    check(start_cnt == base + 4 && exp_q.size() == 0, "R7 no start after abort", start_cnt - base, 4);
    auto_en = 1;

    // pause mode 3..4
    base = start_cnt;
    exp_q.push_back(3);
    reg_wr(mk(0, 1, 0, 0, 1'b1, 2'b10, 3'd3, 3'd4));
    wait_bit(12, 1, "R6 pause reached");
    idle(8);
    check(bus_rdata[15] && start_cnt == base + 1, "R6 holds", start_cnt - base, 1);
    exp_q.push_back(4);
    reg_wr(mk(1, 1, 0, 0, 1'b1, 2'b10, 3'd3, 3'd4)); #1;
    check(bus_rdata[12] == 0, "R6 trigger resumes", bus_rdata[12], 0);
    wait_bit(12, 1, "R6 second pause");
    exp_q.push_back(3);
    reg_wr(mk(1, 1, 0, 0, 1'b1, 2'b10, 3'd3, 3'd4));
    wait_bit(12, 1, "R6 third pause");
    check(exp_q.size() == 0, "R6 wrap to start", exp_q.size(), 0);
    reg_wr(mk(0, 1, 0, 0, 1'b0, 2'b10, 3'd3, 3'd4)); #1;
    check(bus_rdata[15:12] == 4'b0100, "R7 abort clears flags", bus_rdata[15:12], 4);

    // external trigger select 01, channel 5
    reg_wr(mk(0, 1, 0, 2'b01, 1'b0, 2'b00, 3'd5, 3'd5));
    base = start_cnt;
    @(negedge clk); ext_trig = 3'b010; idle(2); ext_trig = 0; idle(5);
    check(start_cnt == base && bus_rdata[15] == 0, "R2 unselected line", start_cnt - base, 0);
    exp_q.push_back(5);
    @(negedge clk); ext_trig = 3'b001; idle(2); ext_trig = 0;
    wait_bit(15, 0, "R2 external scan completes");
    check(start_cnt == base + 1 && exp_q.size() == 0, "R2 selected line", start_cnt - base, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule